// File: doc/BRIEF.md
# Clock-Disable Mask Loader

This block captures a clock-disable mask from an external parallel-in serial-out shift register. The capture happens while the secondary bus is still held in reset. Two general-purpose pins are borrowed for the capture: one carries the shift clock and the other an active-low parallel-load strobe. A dedicated serial input supplies the data. The sequence starts once primary reset is seen released. It loads the external register with a single strobed shift-clock pulse, then takes exactly sixteen bits, most significant first. After the last bit it hands the borrowed pins back (drive enable low) and stops listening to the serial input. From then on it allows the secondary reset to lift, unless the secondary reset control bit is set.

The captured mask stays live as a configuration register that software can read and rewrite. Each secondary clock output is modelled as a registered enable. A mask bit of 0 lets the matching clock run, and a bit of 1 stops it (enable low). The last clock output is the one that feeds the block's own secondary clock input. It is governed by mask bit 13 rather than by its own index. The two top mask bits are reserved. A synchronous, active-high chip reset restarts the whole capture.

Top module: `clkmask_loader`

## Requirements
- R1: While and just after chip reset `rst`: `gpio_drv_en` is 1, `gpio_ld_n` is 1, `gpio_shclk` is 0, `sec_rst_n` is 0, `cfg_rd_data` is 0 and every `clk_en` bit is 1.
- R2: Once `prim_rst_n` is seen high, the sequence gives exactly one rising edge of `gpio_shclk` with `gpio_ld_n` low, then exactly sixteen rising edges with `gpio_ld_n` high. Each shift clock period is 2*SHCLK_HALF cycles, so `gpio_drv_en` falls 17*2*SHCLK_HALF clock edges after the edge that first sees `prim_rst_n` high.
- R3: The value of `mask_sdi` at each clock edge that raises `gpio_shclk` during shifting is captured. The first captured value becomes mask bit 15 and the last becomes bit 0.
- R4: When the sixteenth bit has been taken, the mask is committed, `gpio_drv_en` drops to 0, and `gpio_shclk`/`gpio_ld_n` return to 0/1. After that, `mask_sdi` has no effect on `cfg_rd_data`.
- R5: `clk_en[i]` for i below N_CLK-1 is the inverse of mask bit i. `clk_en[N_CLK-1]` is the inverse of mask bit 13. A 0 bit enables the output and a 1 bit disables it.
- R6: Mask bits 15:14 are reserved. They always read 0, whatever is shifted in or written.
- R7: `sec_rst_n` goes high only after the capture has finished and while `sec_rst_req` is 0. It follows `sec_rst_req` one clock edge later.
- R8: A configuration write (`cfg_wr_en` high at an edge) after capture updates `cfg_rd_data` at that edge, and `clk_en` at the next edge.
- R9: A configuration write made before the capture has finished is ignored.
- R10: Asserting `rst` in the middle of a capture aborts it, returns the outputs to the R1 state, and restarts the full sequence.
- R11: While `prim_rst_n` is low after reset, no shift clock edge and no load strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high chip reset; restarts the capture |
| prim_rst_n | input | 1 | Primary reset, active low; capture starts when it is high |
| sec_rst_req | input | 1 | Secondary reset control bit from configuration space |
| sec_rst_n | output | 1 | Secondary reset, active low |
| gpio_shclk | output | 1 | Shift clock driven onto the borrowed pin 0 |
| gpio_ld_n | output | 1 | Active-low parallel-load strobe driven onto the borrowed pin 2 |
| gpio_drv_en | output | 1 | Output enable for both borrowed pins; 0 releases them |
| mask_sdi | input | 1 | Serial mask data |
| cfg_wr_en | input | 1 | Configuration write strobe for the mask |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Current mask value |
| clk_en | output | N_CLK | Per-output secondary clock enables |

## Verification
The end of the capture lands a fixed 17*2*SHCLK_HALF edges after `prim_rst_n` is first seen high. The bench therefore counts falling-edge samples from that point, and it counts shift clock and load-strobe rising edges with a model of the external shift register. A committed mask is visible on `cfg_rd_data` at the sample right after the commit edge. The enables and `sec_rst_n` appear one sample later. For every configuration write, the bench checks `cfg_rd_data` at the next sample and confirms that `clk_en` still holds its old value there. It then checks `clk_en` one sample after that. A change on `sec_rst_req` is checked one sample after it is driven, and writes made before the capture is done are judged by reading the mask after the capture.

// File: rtl/cml_pkg.sv
package cml_pkg;

    localparam int MASK_W = 16;
    localparam int FB_BIT = 13;
    localparam logic [MASK_W-1:0] LIVE_BITS = 16'h3FFF;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic shclk;
        logic ld_n;
        logic drv_en;
    } pin_ctl_t;

    // Mask bit that governs clock output idx; the last output is the feedback clock.
    function automatic int gate_bit(input int idx, input int n_clk);
        return (idx == n_clk - 1) ? FB_BIT : idx;
    endfunction

endpackage

// File: rtl/cml_seq.sv
module cml_seq
    import cml_pkg::*;
#(
    parameter int HALF  = 2,
    parameter int NBITS = MASK_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     prim_rst_n,
    output pin_ctl_t pins,
    output logic     cap_stb,
    output logic     done_stb,
    output logic     load_done
);
    localparam int PER  = 2 * HALF;
    localparam int PH_W = (PER > 1) ? $clog2(PER) : 1;
    localparam int BC_W = (NBITS > 1) ? $clog2(NBITS) : 1;

    seq_state_e      st, st_n;
    logic [PH_W-1:0] ph, ph_n;
    logic [BC_W-1:0] bc, bc_n;
    logic            wrap;
    logic            running_n;

    assign wrap = (ph == PH_W'(PER - 1));

    always_comb begin
        st_n = st;
        ph_n = ph;
        bc_n = bc;
        case (st)
            S_IDLE: begin
                if (prim_rst_n) begin
                    st_n = S_LOAD;
                    ph_n = '0;
                end
            end
            S_LOAD: begin
                ph_n = wrap ? '0 : ph + 1'b1;
                if (wrap) begin
                    st_n = S_SHIFT;
                    bc_n = '0;
                end
            end
            S_SHIFT: begin
                ph_n = wrap ? '0 : ph + 1'b1;
                if (wrap) begin
                    if (bc == BC_W'(NBITS - 1)) begin
                        st_n = S_DONE;
                    end else begin
                        bc_n = bc + 1'b1;
                    end
                end
            end
            default: begin
                st_n = S_DONE;
            end
        endcase
    end

    assign running_n = (st_n == S_LOAD) || (st_n == S_SHIFT);
    assign cap_stb   = (st == S_SHIFT) && (ph == PH_W'(HALF - 1));
    assign done_stb  = (st == S_SHIFT) && wrap && (bc == BC_W'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            ph          <= '0;
            bc          <= '0;
            pins.shclk  <= 1'b0;
            pins.ld_n   <= 1'b1;
            pins.drv_en <= 1'b1;
            load_done   <= 1'b0;
        end else begin
            st          <= st_n;
            ph          <= ph_n;
            bc          <= bc_n;
            pins.shclk  <= running_n && (int'(ph_n) >= HALF);
            pins.ld_n   <= (st_n != S_LOAD);
            pins.drv_en <= (st_n != S_DONE);
            load_done   <= (st_n == S_DONE);
        end
    end

endmodule

// File: rtl/cml_shreg.sv
module cml_shreg
    import cml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_stb,
    input  logic              sdi,
    output logic [MASK_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (cap_stb) begin
            word <= {word[MASK_W-2:0], sdi};
        end
    end

endmodule

// File: rtl/cml_regs.sv
module cml_regs
    import cml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_stb,
    input  logic              load_done,
    input  logic              sec_rst_req,
    input  logic              cfg_wr_en,
    input  logic [MASK_W-1:0] cfg_wr_data,
    input  logic [MASK_W-1:0] sh_word,
    output logic [MASK_W-1:0] mask_q,
    output logic              sec_rst_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            sec_rst_n <= 1'b0;
        end else begin
            if (done_stb) begin
                mask_q <= sh_word & LIVE_BITS;
            end else if (cfg_wr_en && load_done) begin
                mask_q <= cfg_wr_data & LIVE_BITS;
            end
            sec_rst_n <= load_done && !sec_rst_req;
        end
    end

endmodule

// File: rtl/cml_gate.sv
module cml_gate #(
    parameter int N_CLK = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CLK-1:0] dis_sel,
    output logic [N_CLK-1:0] clk_en
);
    for (genvar i = 0; i < N_CLK; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                clk_en[i] <= 1'b1;
            end else begin
                clk_en[i] <= !dis_sel[i];
            end
        end
    end

endmodule

// File: rtl/clkmask_loader.sv
module clkmask_loader
    import cml_pkg::*;
#(
    parameter int N_CLK      = 10,
    parameter int SHCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prim_rst_n,
    input  logic              sec_rst_req,
    output logic              sec_rst_n,
    output logic              gpio_shclk,
    output logic              gpio_ld_n,
    output logic              gpio_drv_en,
    input  logic              mask_sdi,
    input  logic              cfg_wr_en,
    input  logic [MASK_W-1:0] cfg_wr_data,
    output logic [MASK_W-1:0] cfg_rd_data,
    output logic [N_CLK-1:0]  clk_en
);
    pin_ctl_t          pins;
    logic              cap_stb;
    logic              done_stb;
    logic              load_done;
    logic [MASK_W-1:0] sh_word;
    logic [MASK_W-1:0] mask_q;
    logic [N_CLK-1:0]  dis_sel;

    cml_seq #(
        .HALF (SHCLK_HALF),
        .NBITS(MASK_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .prim_rst_n(prim_rst_n),
        .pins      (pins),
        .cap_stb   (cap_stb),
        .done_stb  (done_stb),
        .load_done (load_done)
    );

    cml_shreg u_shreg (
        .clk    (clk),
        .rst    (rst),
        .cap_stb(cap_stb),
        .sdi    (mask_sdi),
        .word   (sh_word)
    );

    cml_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .done_stb   (done_stb),
        .load_done  (load_done),
        .sec_rst_req(sec_rst_req),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_wr_data(cfg_wr_data),
        .sh_word    (sh_word),
        .mask_q     (mask_q),
        .sec_rst_n  (sec_rst_n)
    );

    for (genvar i = 0; i < N_CLK; i++) begin : g_sel
        assign dis_sel[i] = mask_q[gate_bit(i, N_CLK)];
    end

    cml_gate #(
        .N_CLK(N_CLK)
    ) u_gate (
        .clk    (clk),
        .rst    (rst),
        .dis_sel(dis_sel),
        .clk_en (clk_en)
    );

    assign gpio_shclk  = pins.shclk;
    assign gpio_ld_n   = pins.ld_n;
    assign gpio_drv_en = pins.drv_en;
    assign cfg_rd_data = mask_q;

endmodule

// File: rtl/cml_chk.sv
module cml_chk
    import cml_pkg::*;
#(
    parameter int N_CLK = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              gpio_shclk,
    input logic              gpio_ld_n,
    input logic              gpio_drv_en,
    input logic              cfg_wr_en,
    input logic [MASK_W-1:0] cfg_rd_data,
    input logic [N_CLK-1:0]  clk_en,
    input logic              sec_rst_n
);
    p_ld_owned_r2: assert property (@(posedge clk) disable iff (rst)
        !gpio_ld_n |-> gpio_drv_en);

    p_shclk_owned_r4: assert property (@(posedge clk) disable iff (rst)
        gpio_shclk |-> gpio_drv_en);

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!gpio_drv_en && !cfg_wr_en) |=> $stable(cfg_rd_data));

    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[MASK_W-1:MASK_W-2] == 2'b00);

    p_sec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        sec_rst_n |-> !gpio_drv_en);

    p_fb_gate_r5: assert property (@(posedge clk) disable iff (rst)
        clk_en[N_CLK-1] == !$past(cfg_rd_data[FB_BIT]));

    for (genvar i = 0; i < N_CLK - 1; i++) begin : g_gate
        p_gate_follow_r5: assert property (@(posedge clk) disable iff (rst)
            clk_en[i] == !$past(cfg_rd_data[i]));
    end

endmodule

bind clkmask_loader cml_chk #(
    .N_CLK(N_CLK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .gpio_shclk (gpio_shclk),
    .gpio_ld_n  (gpio_ld_n),
    .gpio_drv_en(gpio_drv_en),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_rd_data(cfg_rd_data),
    .clk_en     (clk_en),
    .sec_rst_n  (sec_rst_n)
);

// File: tb/tb_clkmask_loader.sv
`timescale 1ns/1ps
module tb_clkmask_loader;
    localparam int N_CLK = 10;
    localparam int HALF  = 2;
    localparam int PER   = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prim_rst_n = 1'b0;
    logic        sec_rst_req = 1'b0;
    logic        sec_rst_n;
    logic        gpio_shclk, gpio_ld_n, gpio_drv_en;
    logic        mask_sdi;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic [15:0] cfg_rd_data;
    logic [N_CLK-1:0] clk_en;

    logic [15:0] ext_word = '0;
    logic [15:0] ext_sr = '0;
    logic        sdi_force_en = 1'b0;
    logic        sdi_force = 1'b0;
    int          shc_rises = 0;
    int          ld_rises = 0;
    int          n_checks = 0;
    int          n_fails = 0;

    always #4 clk = ~clk;

    clkmask_loader #(.N_CLK(N_CLK), .SHCLK_HALF(HALF)) dut (
        .clk(clk), .rst(rst), .prim_rst_n(prim_rst_n), .sec_rst_req(sec_rst_req),
        .sec_rst_n(sec_rst_n), .gpio_shclk(gpio_shclk), .gpio_ld_n(gpio_ld_n),
        .gpio_drv_en(gpio_drv_en), .mask_sdi(mask_sdi), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .clk_en(clk_en)
    );

    // External parallel-in serial-out register model
    always @(posedge gpio_shclk) begin
        shc_rises = shc_rises + 1;
        if (!gpio_ld_n) begin
            ld_rises = ld_rises + 1;
            ext_sr <= ext_word;
        end else begin
            ext_sr <= {ext_sr[14:0], 1'b0};
        end
    end
    assign mask_sdi = sdi_force_en ? sdi_force : ext_sr[15];

    function automatic logic [N_CLK-1:0] exp_en(input logic [15:0] m);
        logic [N_CLK-1:0] r;
        for (int i = 0; i < N_CLK - 1; i++) r[i] = !m[i];
        r[N_CLK-1] = !m[13];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic check_reset_state(input string req);
        check(gpio_drv_en === 1'b1, req, 32'(gpio_drv_en), 32'd1);
        check(gpio_ld_n === 1'b1, req, 32'(gpio_ld_n), 32'd1);
        check(gpio_shclk === 1'b0, req, 32'(gpio_shclk), 32'd0);
        check(sec_rst_n === 1'b0, req, 32'(sec_rst_n), 32'd0);
        check(cfg_rd_data === 16'h0, req, 32'(cfg_rd_data), 32'd0);
        check(clk_en === '1, req, 32'(clk_en), 32'h3FF);
    endtask

    task automatic run_load(input logic [15:0] word, input logic req, input bit abort);
        int n;
        int r0;
        int l0;
        logic [15:0] exp_m;
        @(negedge clk);
        rst = 1'b1; prim_rst_n = 1'b0; sec_rst_req = req; sdi_force_en = 1'b0;
        cfg_wr_en = 1'b0; ext_word = word;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1");
        // R9: write while capture has not finished
        cfg_wr_en = 1'b1; cfg_wr_data = ~word;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        @(negedge clk);
        check(cfg_rd_data === 16'h0, "R9", 32'(cfg_rd_data), 32'd0);
        // R11: quiet while primary reset is held
        r0 = shc_rises; l0 = ld_rises;
        repeat (3) @(negedge clk);
        check((shc_rises == r0) && (ld_rises == l0) && gpio_ld_n === 1'b1, "R11",
              32'(shc_rises - r0), 32'd0);
        prim_rst_n = 1'b1;
        if (abort) begin
            repeat (20) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            check_reset_state("R10");
            rst = 1'b0;
        end
        r0 = shc_rises; l0 = ld_rises; n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (gpio_drv_en && n < 500);
        check(n == 17 * PER + 1, "R2", 32'(n), 32'(17 * PER + 1));
        check(shc_rises - r0 == 17, "R2", 32'(shc_rises - r0), 32'd17);
        check(ld_rises - l0 == 1, "R2", 32'(ld_rises - l0), 32'd1);
        exp_m = word & 16'h3FFF;
        check(cfg_rd_data === exp_m, abort ? "R10" : "R3", 32'(cfg_rd_data), 32'(exp_m));
        check(cfg_rd_data[15:14] === 2'b00, "R6", 32'(cfg_rd_data[15:14]), 32'd0);
        check(gpio_ld_n === 1'b1 && gpio_shclk === 1'b0, "R4",
              32'({gpio_ld_n, gpio_shclk}), 32'h2);
        @(negedge clk);
        check(clk_en === exp_en(exp_m), "R5", 32'(clk_en), 32'(exp_en(exp_m)));
        check(sec_rst_n === !req, "R7", 32'(sec_rst_n), 32'(!req));
    endtask

    task automatic sdi_ignore();
        logic [15:0] held;
        held = cfg_rd_data;
        sdi_force_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            sdi_force = 1'($urandom);
            @(negedge clk);
        end
        sdi_force_en = 1'b0;
        check(cfg_rd_data === held, "R4", 32'(cfg_rd_data), 32'(held));
    endtask

    task automatic cfg_write(input logic [15:0] data);
        logic [N_CLK-1:0] old_en;
        logic [15:0] exp_m;
        old_en = clk_en;
        exp_m = data & 16'h3FFF;
        cfg_wr_en = 1'b1; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check(cfg_rd_data === exp_m, "R8", 32'(cfg_rd_data), 32'(exp_m));
        check(cfg_rd_data[15:14] === 2'b00, "R6", 32'(cfg_rd_data[15:14]), 32'd0);
        check(clk_en === old_en, "R8", 32'(clk_en), 32'(old_en));
        @(negedge clk);
        check(clk_en === exp_en(exp_m), "R5", 32'(clk_en), 32'(exp_en(exp_m)));
    endtask

    task automatic toggle_req();
        sec_rst_req = ~sec_rst_req;
        @(negedge clk);
        check(sec_rst_n === !sec_rst_req, "R7", 32'(sec_rst_n), 32'(!sec_rst_req));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        run_load(16'h0000, 1'b0, 1'b0);
        cfg_write(16'hFFFF);
        cfg_write(16'h2000);
        toggle_req();
        toggle_req();
        run_load(16'hFFFF, 1'b1, 1'b0);
        toggle_req();
        sdi_ignore();
        run_load(16'hA5C3, 1'b0, 1'b1);
        run_load(16'h2000, 1'b0, 1'b0);
        cfg_write(16'hC000);
        for (int it = 0; it < 8; it++) begin
            run_load(16'($urandom), 1'($urandom), (it % 3) == 1);
            sdi_ignore();
            for (int w = 0; w < 4; w++) cfg_write(16'($urandom));
            toggle_req();
        end
        summary();
        $finish;
    end

endmodule